// File: doc/BRIEF.md
# Half-Bridge Fault Protection Controller

This block stands between the firmware-requested gate commands for four half-bridge outputs and the gate drivers. It watches synchronous, already digitised fault inputs: overcurrent on the high side and on the low side, undervoltage, overvoltage and overtemperature. When a fault appears, it removes the gate commands that the fault calls for. Each fault leaves a sticky flag. Software reads the flags and clears them by writing 1 through a byte-wide register bus.

Overcurrent on one side switches off that side on every bridge and leaves the other side running. A supply fault in either direction switches off every output. An overtemperature input only raises a warning flag, unless the thermal shutdown enable pin is high. With the pin high, the block emits a one-cycle reset request, clears all of its flags and its bridge control register, and holds every output off for as long as the overtemperature input stays high.

The bridge control register is also reachable on the same bus. It holds the offset-chopping enable, the current-sense select and the current-limit select. This block only stores those fields; it does not act on them.

Top module: `hbridge_guard`

## Requirements
- R1: After reset, every readable register returns 0, `rstReq` is low and each gate output equals its request input.
- R2: A cycle with `ocHigh` high forces every bit of `gateHigh` to 0 from the next cycle on, until the overcurrent flag is cleared. `gateLow` is not affected by this input.
- R3: A cycle with `ocLow` high forces every bit of `gateLow` to 0 from the next cycle on, until the overcurrent flag is cleared. `gateHigh` is not affected by this input.
- R4: Either overcurrent input sets one shared overcurrent flag. It reads as bit 0 at address 1, and the other bits at that address read 0.
- R5: Writing 1 to bit 0 at address 1 clears the overcurrent flag and both side shutdowns, so the outputs follow their requests again on the next cycle. Writing 0 to any flag bit changes nothing.
- R6: Address 0 holds the under-voltage flag (bit 0), the over-voltage flag (bit 1) and the temperature-warning flag (bit 2), all write-1-to-clear. While either voltage flag is set, all gate outputs are 0.
- R7: When a write-clear and an active fault fall in the same cycle, the fault wins and the flag stays set. A voltage flag therefore cannot be cleared while its condition is present.
- R8: With `thermShutEn` low, `overTemp` sets the temperature-warning flag and has no effect on the gate outputs or on `rstReq`.
- R9: With `thermShutEn` high, the first cycle of `overTemp` produces a `rstReq` pulse exactly one cycle long on the next cycle. In that same update it clears every flag, both side shutdowns and the bridge control register. All gates stay 0 for every cycle that follows a cycle in which the trip condition was present.
- R10: Address 2 holds the bridge control register: offset-chopping enable at bit 4, current-sense select at bit 3 and current-limit select at bits 2:0. Bits 7:5 read 0. Addresses 3 to 7 read 0.
- R11: `busRdData` is combinational and shows the register selected by `busAddr` in the same cycle. A write takes effect at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busWr | input | 1 | Write strobe for the register bus |
| busAddr | input | 3 | Register address |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data for `busAddr` |
| ocHigh | input | 1 | High-side overcurrent detected |
| ocLow | input | 1 | Low-side overcurrent detected |
| underVolt | input | 1 | Supply below its limit |
| overVolt | input | 1 | Supply above its limit |
| overTemp | input | 1 | Temperature limit reached |
| thermShutEn | input | 1 | Turns an overtemperature into a reset and shutdown |
| reqHigh | input | 4 | Requested high-side gate commands |
| reqLow | input | 4 | Requested low-side gate commands |
| gateHigh | output | 4 | Masked high-side gate commands |
| gateLow | output | 4 | Masked low-side gate commands |
| rstReq | output | 1 | One-cycle reset request |

## Verification
A wrong side-shutdown mask or a wrong voltage flag shows on the gate outputs in the very cycle after the fault is sampled, because the gates are a direct function of that state and the requests. Flag state that is stuck or cleared when it should not be shows when the flag address is read. The bench reads a random address every cycle, so the error appears within a few cycles. A faulty trip edge detector shows as a `rstReq` pulse that is missing, doubled or one cycle too long, and as a bridge control register that survives the trip.

// File: rtl/hbg_pkg.sv
package hbg_pkg;

  localparam logic [7:0] ADDR_ALERT  = 8'h00;
  localparam logic [7:0] ADDR_STATUS = 8'h01;
  localparam logic [7:0] ADDR_BRIDGE = 8'h02;

  localparam int BIT_UNDER = 0;
  localparam int BIT_OVER  = 1;
  localparam int BIT_HOT   = 2;
  localparam int BIT_OC    = 0;

  localparam logic [7:0] BRIDGE_MASK = 8'h1F;

  typedef struct packed {
    logic       clrUnder;
    logic       clrOver;
    logic       clrHot;
    logic       clrOc;
    logic       wrBridge;
    logic       tripRise;
    logic [7:0] wrData;
  } hbg_strobe_t;

endpackage

// File: rtl/hbg_ctrl.sv
module hbg_ctrl
  import hbg_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [7:0]        busWrData,
  input  logic              overTemp,
  input  logic              thermShutEn,
  output hbg_strobe_t       str,
  output logic              tripActive,
  output logic              rstReq
);

  logic tripNow;
  logic tripQ;
  logic selAlert, selStatus, selBridge;

  assign tripNow   = overTemp & thermShutEn;
  assign selAlert  = busWr && (busAddr == ADDR_ALERT[ADDR_W-1:0]);
  assign selStatus = busWr && (busAddr == ADDR_STATUS[ADDR_W-1:0]);
  assign selBridge = busWr && (busAddr == ADDR_BRIDGE[ADDR_W-1:0]);

  always_comb begin
    str          = '0;
    str.wrData   = busWrData;
    str.clrUnder = selAlert  & busWrData[BIT_UNDER];
    str.clrOver  = selAlert  & busWrData[BIT_OVER];
    str.clrHot   = selAlert  & busWrData[BIT_HOT];
    str.clrOc    = selStatus & busWrData[BIT_OC];
    str.wrBridge = selBridge;
    str.tripRise = tripNow & ~tripQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tripQ  <= 1'b0;
      rstReq <= 1'b0;
    end else begin
      tripQ  <= tripNow;
      rstReq <= tripNow & ~tripQ;
    end
  end

  assign tripActive = tripQ;

  // R9: the reset request never lasts longer than one cycle
  p_rst_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    rstReq |=> !rstReq);

  // R8: without the enable, temperature never produces a reset request
  p_no_trip_r8: assert property (@(posedge clk) disable iff (!rstN)
    !thermShutEn |=> !rstReq);

endmodule

// File: rtl/hbg_datapath.sv
module hbg_datapath
  import hbg_pkg::*;
#(
  parameter int NUM_HB = 4,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  hbg_strobe_t       str,
  input  logic              tripActive,
  input  logic              ocHigh,
  input  logic              ocLow,
  input  logic              underVolt,
  input  logic              overVolt,
  input  logic              overTemp,
  input  logic [NUM_HB-1:0] reqHigh,
  input  logic [NUM_HB-1:0] reqLow,
  input  logic [ADDR_W-1:0] busAddr,
  output logic [NUM_HB-1:0] gateHigh,
  output logic [NUM_HB-1:0] gateLow,
  output logic [7:0]        busRdData
);

  logic underFlag, overFlag, hotFlag, ocFlag;
  logic hsMask, lsMask;
  logic [7:0] bridgeReg;
  logic ocAny, ocRelease;
  logic highOn, lowOn;

  assign ocAny     = ocHigh | ocLow;
  assign ocRelease = str.clrOc & ~ocAny;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      underFlag <= 1'b0;
      overFlag  <= 1'b0;
      hotFlag   <= 1'b0;
      ocFlag    <= 1'b0;
      hsMask    <= 1'b0;
      lsMask    <= 1'b0;
      bridgeReg <= '0;
    end else if (str.tripRise) begin
      underFlag <= 1'b0;
      overFlag  <= 1'b0;
      hotFlag   <= 1'b0;
      ocFlag    <= 1'b0;
      hsMask    <= 1'b0;
      lsMask    <= 1'b0;
      bridgeReg <= '0;
    end else begin
      underFlag <= (underFlag & ~str.clrUnder) | underVolt;
      overFlag  <= (overFlag  & ~str.clrOver)  | overVolt;
      hotFlag   <= (hotFlag   & ~str.clrHot)   | overTemp;
      ocFlag    <= (ocFlag    & ~str.clrOc)    | ocAny;
      hsMask    <= ocHigh | (hsMask & ~ocRelease);
      lsMask    <= ocLow  | (lsMask & ~ocRelease);
      if (str.wrBridge) bridgeReg <= str.wrData & BRIDGE_MASK;
    end
  end

  assign highOn = ~(hsMask | underFlag | overFlag | tripActive);
  assign lowOn  = ~(lsMask | underFlag | overFlag | tripActive);

  for (genvar g = 0; g < NUM_HB; g++) begin : g_gate
    assign gateHigh[g] = reqHigh[g] & highOn;
    assign gateLow[g]  = reqLow[g]  & lowOn;
  end

  always_comb begin
    busRdData = '0;
    if (busAddr == ADDR_ALERT[ADDR_W-1:0]) begin
      busRdData[BIT_UNDER] = underFlag;
      busRdData[BIT_OVER]  = overFlag;
      busRdData[BIT_HOT]   = hotFlag;
    end else if (busAddr == ADDR_STATUS[ADDR_W-1:0]) begin
      busRdData[BIT_OC] = ocFlag;
    end else if (busAddr == ADDR_BRIDGE[ADDR_W-1:0]) begin
      busRdData = bridgeReg;
    end
  end

  p_hs_shut_r2: assert property (@(posedge clk) disable iff (!rstN)
    (ocHigh && !str.tripRise) |=> (gateHigh == '0));

  p_ls_shut_r3: assert property (@(posedge clk) disable iff (!rstN)
    (ocLow && !str.tripRise) |=> (gateLow == '0));

  p_oc_flag_r4: assert property (@(posedge clk) disable iff (!rstN)
    (ocAny && !str.tripRise) |=> ocFlag);

  p_volt_off_r6: assert property (@(posedge clk) disable iff (!rstN)
    ((underVolt || overVolt) && !str.tripRise) |=> (gateHigh == '0 && gateLow == '0));

  p_fault_wins_r7: assert property (@(posedge clk) disable iff (!rstN)
    (underVolt && str.clrUnder && !str.tripRise) |=> underFlag);

  p_trip_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    str.tripRise |=> (bridgeReg == '0 && !ocFlag));

  p_bridge_hi_r10: assert property (@(posedge clk) disable iff (!rstN)
    bridgeReg[7:5] == 3'b000);

endmodule

// File: rtl/hbridge_guard.sv
module hbridge_guard
  import hbg_pkg::*;
#(
  parameter int NUM_HB = 4,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [7:0]        busWrData,
  output logic [7:0]        busRdData,
  input  logic              ocHigh,
  input  logic              ocLow,
  input  logic              underVolt,
  input  logic              overVolt,
  input  logic              overTemp,
  input  logic              thermShutEn,
  input  logic [NUM_HB-1:0] reqHigh,
  input  logic [NUM_HB-1:0] reqLow,
  output logic [NUM_HB-1:0] gateHigh,
  output logic [NUM_HB-1:0] gateLow,
  output logic              rstReq
);

  hbg_strobe_t str;
  logic        tripActive;

  hbg_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
    .busWrData(busWrData), .overTemp(overTemp), .thermShutEn(thermShutEn),
    .str(str), .tripActive(tripActive), .rstReq(rstReq)
  );

  hbg_datapath #(.NUM_HB(NUM_HB), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .str(str), .tripActive(tripActive),
    .ocHigh(ocHigh), .ocLow(ocLow), .underVolt(underVolt),
    .overVolt(overVolt), .overTemp(overTemp),
    .reqHigh(reqHigh), .reqLow(reqLow), .busAddr(busAddr),
    .gateHigh(gateHigh), .gateLow(gateLow), .busRdData(busRdData)
  );

endmodule

// File: tb/test_hbridge_guard.sv
module test_hbridge_guard;

  localparam int N = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busWr = 1'b0;
  logic [2:0] busAddr = '0;
  logic [7:0] busWrData = '0;
  logic [7:0] busRdData;
  logic ocHigh = 0, ocLow = 0, underVolt = 0, overVolt = 0, overTemp = 0, thermShutEn = 0;
  logic [N-1:0] reqHigh = '0, reqLow = '0;
  logic [N-1:0] gateHigh, gateLow;
  logic rstReq;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // independent expected state
  logic mUnder = 0, mOver = 0, mHot = 0, mOc = 0, mHs = 0, mLs = 0, mTripQ = 0, mRst = 0;
  logic [4:0] mCtrl = '0;

  always #10 clk = ~clk;

  hbridge_guard #(.NUM_HB(N), .ADDR_W(3)) i_hbridge_guard (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr), .busWrData(busWrData),
    .busRdData(busRdData), .ocHigh(ocHigh), .ocLow(ocLow), .underVolt(underVolt),
    .overVolt(overVolt), .overTemp(overTemp), .thermShutEn(thermShutEn),
    .reqHigh(reqHigh), .reqLow(reqLow), .gateHigh(gateHigh), .gateLow(gateLow),
    .rstReq(rstReq)
  );

  function automatic logic [N-1:0] expHigh();
    return (mHs | mUnder | mOver | mTripQ) ? '0 : reqHigh;
  endfunction

  function automatic logic [N-1:0] expLow();
    return (mLs | mUnder | mOver | mTripQ) ? '0 : reqLow;
  endfunction

  function automatic logic [7:0] expRead(input logic [2:0] a);
    case (a)
      3'd0: return {5'b0, mHot, mOver, mUnder};
      3'd1: return {7'b0, mOc};
      3'd2: return {3'b0, mCtrl};
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic modelUpdate();
    logic trip, rise, cU, cO, cH, cOc, rel;
    trip = overTemp & thermShutEn;
    rise = trip & ~mTripQ;
    cU = busWr && busAddr == 3'd0 && busWrData[0];
    cO = busWr && busAddr == 3'd0 && busWrData[1];
    cH = busWr && busAddr == 3'd0 && busWrData[2];
    cOc = busWr && busAddr == 3'd1 && busWrData[0];
    rel = cOc & ~(ocHigh | ocLow);
    if (rise) begin
      {mUnder, mOver, mHot, mOc, mHs, mLs} = '0;
      mCtrl = '0;
    end else begin
      mUnder = (mUnder & ~cU) | underVolt;
      mOver  = (mOver & ~cO) | overVolt;
      mHot   = (mHot & ~cH) | overTemp;
      mOc    = (mOc & ~cOc) | ocHigh | ocLow;
      mHs    = ocHigh | (mHs & ~rel);
      mLs    = ocLow | (mLs & ~rel);
      if (busWr && busAddr == 3'd2) mCtrl = busWrData[4:0];
    end
    mRst = rise;
    mTripQ = trip;
  endtask

  // inputs are set by the caller at a falling edge; compare, clock, update model
  task automatic step();
    #1;
    check("R2 gateHigh", {4'b0, gateHigh}, {4'b0, expHigh()});
    check("R3 gateLow", {4'b0, gateLow}, {4'b0, expLow()});
    check("R11 busRdData", busRdData, expRead(busAddr));
    check("R9 rstReq", {7'b0, rstReq}, {7'b0, mRst});
    @(posedge clk);
    modelUpdate();
    @(negedge clk);
  endtask

  task automatic idle();
    busWr = 0; ocHigh = 0; ocLow = 0; underVolt = 0; overVolt = 0; overTemp = 0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    busWr = 1; busAddr = a; busWrData = d;
    step();
    busWr = 0;
  endtask

  task automatic rd(input string tag, input logic [2:0] a, input logic [7:0] exp);
    busAddr = a;
    #1;
    check(tag, busRdData, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    reqHigh = 4'hF; reqLow = 4'hF;
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1: reset state
    for (int a = 0; a < 8; a++) rd("R1 read after reset", 3'(a), 8'h00);
    check("R1 gateHigh after reset", {4'b0, gateHigh}, 8'h0F);
    check("R1 rstReq after reset", {7'b0, rstReq}, 8'h00);
    step();

    // R2, R4, R5: high-side overcurrent
    reqHigh = 4'hA; reqLow = 4'h5;
    ocHigh = 1; step(); ocHigh = 0;
    check("R2 high side off", {4'b0, gateHigh}, 8'h00);
    check("R2 low side kept", {4'b0, gateLow}, 8'h05);
    rd("R4 status flag", 3'd1, 8'h01);
    wr(3'd1, 8'h00);
    rd("R5 write 0 no effect", 3'd1, 8'h01);
    check("R5 still off", {4'b0, gateHigh}, 8'h00);
    wr(3'd1, 8'h01);
    rd("R5 flag cleared", 3'd1, 8'h00);
    check("R5 re-enabled", {4'b0, gateHigh}, 8'h0A);
    step();

    // R3: low-side overcurrent
    ocLow = 1; step(); ocLow = 0;
    check("R3 low side off", {4'b0, gateLow}, 8'h00);
    check("R3 high side kept", {4'b0, gateHigh}, 8'h0A);
    wr(3'd1, 8'h01);
    check("R3 low re-enabled", {4'b0, gateLow}, 8'h05);

    // R6, R7: undervoltage held while clearing
    underVolt = 1; step();
    check("R6 all off", {gateHigh, gateLow}, 8'h00);
    wr(3'd0, 8'h01);
    rd("R7 fault wins", 3'd0, 8'h01);
    underVolt = 0; step();
    wr(3'd0, 8'h01);
    rd("R6 cleared", 3'd0, 8'h00);
    overVolt = 1; step(); overVolt = 0;
    rd("R6 over flag bit1", 3'd0, 8'h02);
    wr(3'd0, 8'h02);

    // R8: warning only
    thermShutEn = 0; overTemp = 1; step(); overTemp = 0;
    rd("R8 hot flag", 3'd0, 8'h04);
    check("R8 gates unaffected", {gateHigh, gateLow}, 8'hA5);
    check("R8 no reset", {7'b0, rstReq}, 8'h00);
    wr(3'd0, 8'h04);

    // R10: bridge register
    wr(3'd2, 8'hFF);
    rd("R10 bridge bits", 3'd2, 8'h1F);
    rd("R10 unused addr", 3'd5, 8'h00);

    // R9: thermal trip
    ocHigh = 1; step(); ocHigh = 0;
    thermShutEn = 1; overTemp = 1; step();
    check("R9 pulse", {7'b0, rstReq}, 8'h01);
    rd("R9 bridge cleared", 3'd2, 8'h00);
    rd("R9 oc cleared", 3'd1, 8'h00);
    check("R9 gates off", {gateHigh, gateLow}, 8'h00);
    step();
    check("R9 single cycle", {7'b0, rstReq}, 8'h00);
    overTemp = 0; step();
    thermShutEn = 0; wr(3'd0, 8'h07);

    // randomized traffic
    for (int i = 0; i < 4000; i++) begin
      reqHigh = 4'($urandom); reqLow = 4'($urandom);
      ocHigh = ($urandom % 40) == 0;
      ocLow = ($urandom % 40) == 0;
      underVolt = ($urandom % 35) == 0;
      overVolt = ($urandom % 35) == 0;
      overTemp = ($urandom % 25) < 2;
      if (($urandom % 50) == 0) thermShutEn = ~thermShutEn;
      busWr = ($urandom % 3) == 0;
      busAddr = 3'($urandom);
      busWrData = 8'($urandom);
      step();
    end
    idle();
    step();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule